// File: doc/BRIEF.md
# Vertical Blank Interrupt Controller

This block is the interrupt enable and status pair of a display controller, reached over a small register bus with separate read and write strobes. An internal frame timer stands in for the vertical blank. Each time the timer expires, it sets one status bit. The interrupt output is a level: it stays high while any status bit is also enabled.

Turning on the vertical-blank enable bit raises the status bit at once and starts a fresh frame period. Software therefore receives an interrupt immediately and then one per frame. Writing the enable register with that bit clear halts the timer. Status bits are acknowledged by writing ones. The bits an acknowledge may reach depend on a mask chosen by the device variant, so some status bits cannot be cleared on one variant.

Top module: `vbl_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when the bitwise AND of the status register and the enable register is nonzero.
- R2: A write to the enable register (address 0) whose data has bit VBL_BIT set sets status bit VBL_BIT at the next clock edge and restarts the frame period from zero.
- R3: While the frame timer runs, status bit VBL_BIT is set every PERIOD_CYC cycles, counted from the edge at which the last restart took effect.
- R4: A write to the enable register with bit VBL_BIT clear stops the frame timer. Status keeps its value, and no further frame sets occur until the next restart.
- R5: A write to the status register (address 1) clears each status bit whose written data bit and acknowledge-mask bit are both one. Variant 0 uses mask FC080EFF hex and variant 1 uses mask 000F040F hex. All other status bits keep their value.
- R6: While `bus_rd` is high, `bus_rdata` shows the enable register at address 0, the status register at address 1, and zero at any other address. While `bus_rd` is low, `bus_rdata` is zero.
- R7: A write to any address other than 0 or 1 changes neither register.
- R8: After reset both registers are zero, the timer is stopped and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one transfer per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest condition to show from the ports is that re-enabling truly restarts the period and does not merely set the bit. The stimulus clears status, restarts three cycles after a natural expiry, and then reads status one cycle before and exactly at the new expiry. Under the old schedule that expiry would have come earlier. The variant mask is exercised by a second instance whose frame bit sits outside its mask, so an acknowledge there must leave the bit and the interrupt standing.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
   localparam int unsigned REG_ENABLE = 0;
   localparam int unsigned REG_STATUS = 1;

   localparam logic [31:0] ACK_MASK_V0 = 32'hFC08_0EFF;
   localparam logic [31:0] ACK_MASK_V1 = 32'h000F_040F;
endpackage

// File: rtl/vbl_frame_timer.sv
module vbl_frame_timer #(
   parameter int unsigned PERIOD_CYC = 4_166_667,
   localparam int unsigned CW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   input  logic stop,
   output logic tick
);
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);

   logic          running_q;
   logic [CW-1:0] count_q;

   assign tick = running_q && (count_q == LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         running_q <= 1'b0;
         count_q   <= '0;
      end else if (restart) begin
         running_q <= 1'b1;
         count_q   <= '0;
      end else if (stop) begin
         running_q <= 1'b0;
         count_q   <= '0;
      end else if (running_q) begin
         count_q <= tick ? '0 : count_q + 1'b1;
      end
   end
endmodule

// File: rtl/vbl_irq_regs.sv
module vbl_irq_regs
   import vbl_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned VBL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick,
   input  logic [DATA_W-1:0] ack_mask,
   output logic [DATA_W-1:0] enable_q,
   output logic [DATA_W-1:0] status_q,
   output logic              restart,
   output logic              stop,
   output logic [DATA_W-1:0] rdata
);
   logic sel_en, sel_st, en_wr, st_wr;
   logic [DATA_W-1:0] status_d;

   assign sel_en  = (addr == ADDR_W'(REG_ENABLE));
   assign sel_st  = (addr == ADDR_W'(REG_STATUS));
   assign en_wr   = wr && sel_en;
   assign st_wr   = wr && sel_st;
   assign restart = en_wr && wdata[VBL_BIT];
   assign stop    = en_wr && !wdata[VBL_BIT];

   always_comb begin
      status_d = status_q;
      if (st_wr)
         status_d = status_d & ~(wdata & ack_mask);
      if (tick || restart)
         status_d[VBL_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         enable_q <= '0;
         status_q <= '0;
      end else begin
         if (en_wr)
            enable_q <= wdata;
         status_q <= status_d;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd && sel_en)
         rdata = enable_q;
      else if (rd && sel_st)
         rdata = status_q;
   end
endmodule

// File: rtl/vbl_irq_ctrl.sv
module vbl_irq_ctrl
   import vbl_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned VBL_BIT    = 0,
   parameter int unsigned PERIOD_CYC = 4_166_667,
   parameter int unsigned VARIANT    = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (VBL_BIT >= DATA_W) begin : bad_vbl_bit
      $error("VBL_BIT must lie inside DATA_W");
   end
   if (PERIOD_CYC < 2) begin : bad_period
      $error("PERIOD_CYC must be at least 2");
   end
   if (VARIANT > 1) begin : bad_variant
      $error("VARIANT must be 0 or 1");
   end
   if (ADDR_W < 1) begin : bad_addr_w
      $error("ADDR_W must be at least 1");
   end

   logic [DATA_W-1:0] ack_mask;
   logic [DATA_W-1:0] enable_q, status_q;
   logic              vbl_tick, restart, stop;

   if (VARIANT == 0) begin : g_mask_v0
      assign ack_mask = DATA_W'(ACK_MASK_V0);
   end else begin : g_mask_v1
      assign ack_mask = DATA_W'(ACK_MASK_V1);
   end

   vbl_frame_timer #(.PERIOD_CYC(PERIOD_CYC)) timer_i (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .stop    (stop),
      .tick    (vbl_tick)
   );

   vbl_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VBL_BIT(VBL_BIT)) regs_i (
      .clk      (clk),
      .rst      (rst),
      .wr       (bus_wr),
      .rd       (bus_rd),
      .addr     (bus_addr),
      .wdata    (bus_wdata),
      .tick     (vbl_tick),
      .ack_mask (ack_mask),
      .enable_q (enable_q),
      .status_q (status_q),
      .restart  (restart),
      .stop     (stop),
      .rdata    (bus_rdata)
   );

   assign irq = |(status_q & enable_q);
endmodule

// File: rtl/vbl_irq_ctrl_chk.sv
module vbl_irq_ctrl_chk
   import vbl_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 2,
   parameter int unsigned VBL_BIT    = 0,
   parameter int unsigned PERIOD_CYC = 4_166_667,
   parameter int unsigned VARIANT    = 0,
   localparam int unsigned CW = $clog2(PERIOD_CYC) + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              irq,
   input logic [DATA_W-1:0] enable_q,
   input logic [DATA_W-1:0] status_q,
   input logic              vbl_tick
);
   localparam logic [31:0] MASK32 = (VARIANT == 0) ? ACK_MASK_V0 : ACK_MASK_V1;

   logic en_hit, st_hit, ack_vbl;
   assign en_hit  = bus_wr && (bus_addr == ADDR_W'(REG_ENABLE));
   assign st_hit  = bus_wr && (bus_addr == ADDR_W'(REG_STATUS));
   assign ack_vbl = (VBL_BIT < 32) ? (bus_wdata[VBL_BIT] && MASK32[VBL_BIT % 32]) : 1'b0;

   logic          run_q;
   logic [CW-1:0] since_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         run_q   <= 1'b0;
         since_q <= '0;
      end else if (en_hit) begin
         run_q   <= bus_wdata[VBL_BIT];
         since_q <= '0;
      end else if (run_q) begin
         since_q <= (since_q == CW'(PERIOD_CYC - 1)) ? '0 : since_q + 1'b1;
      end
   end

   // R1
   irq_source_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(irq) |-> ($past(bus_wr) || $past(vbl_tick)));

   // R2
   enable_fire_chk: assert property (@(posedge clk) disable iff (rst)
      (en_hit && bus_wdata[VBL_BIT]) |=> status_q[VBL_BIT]);

   // R3
   frame_period_chk: assert property (@(posedge clk) disable iff (rst)
      vbl_tick |-> (run_q && since_q == CW'(PERIOD_CYC - 1)));

   // R4
   stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!run_q && !en_hit) |=> !$rose(status_q[VBL_BIT]));

   // R5
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (st_hit && ack_vbl && !vbl_tick) |=> !status_q[VBL_BIT]);
endmodule

bind vbl_irq_ctrl vbl_irq_ctrl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VBL_BIT(VBL_BIT),
   .PERIOD_CYC(PERIOD_CYC), .VARIANT(VARIANT)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .enable_q  (enable_q),
   .status_q  (status_q),
   .vbl_tick  (vbl_tick)
);

// File: tb/vbl_irq_ctrl_tb_top.sv
module vbl_irq_ctrl_tb_top;
   localparam int unsigned P = 20;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] rdata_a, rdata_b;
   logic        irq_a, irq_b;

   always #2 clk = ~clk;

   vbl_irq_ctrl #(.PERIOD_CYC(P)) dut_i (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .irq(irq_a));

   vbl_irq_ctrl #(.PERIOD_CYC(P), .VARIANT(1), .VBL_BIT(4)) dut_v1_i (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .irq(irq_b));

   typedef struct {
      logic [31:0] data;
      logic        irq;
      bit          on_b;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 0;

   task automatic rd(input logic [1:0] a, input logic [31:0] d, input logic i,
                     input bit b, input string tag);
      exp_t e;
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = a;
      e.data = d; e.irq = i; e.on_b = b; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         bus_wr = 1'b0; bus_rd = 1'b0;
      end
   endtask

   task automatic pulse_reset();
      @(posedge clk); #1;
      bus_wr = 1'b0; bus_rd = 1'b0; rst = 1'b1;
      @(posedge clk); #1;
      rst = 1'b0;
   endtask

   // monitor: compares each read against the queued expectation
   always @(negedge clk) begin
      if (!rst && bus_rd && q.size() > 0) begin
         exp_t e;
         logic [31:0] ad;
         logic        ai;
         e  = q.pop_front();
         ad = e.on_b ? rdata_b : rdata_a;
         ai = e.on_b ? irq_b : irq_a;
         n_cmp++;
         if (ad !== e.data || ai !== e.irq) begin
            n_bad++;
            $display("FAIL %s: data=%h irq=%b expected data=%h irq=%b",
                     e.tag, ad, ai, e.data, e.irq);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual=expired expected=complete");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // R8 reset state, R6 readback
      rd(0, 32'h0, 1'b0, 0, "R8 enable after reset");
      rd(1, 32'h0, 1'b0, 0, "R8 status after reset");
      // R2 enable fires at once (edge E0)
      wr(0, 32'h1);
      rd(1, 32'h1, 1'b1, 0, "R2 immediate status");          // E0
      rd(0, 32'h1, 1'b1, 0, "R6 enable readback");           // E0+1
      wr(1, 32'h1);                                          // eff E0+3
      rd(1, 32'h0, 1'b0, 0, "R5 ack clears frame bit");      // E0+3
      idle(15);
      rd(1, 32'h0, 1'b0, 0, "R3 one cycle before expiry");   // E0+19
      rd(1, 32'h1, 1'b1, 0, "R3 expiry sets bit");           // E0+20
      wr(1, 32'hFFFF_FFFF);                                  // eff E0+22
      rd(1, 32'h0, 1'b0, 0, "R5 all-ones ack");              // E0+22
      idle(16);
      rd(1, 32'h0, 1'b0, 0, "R3 second frame early");        // E0+39
      rd(1, 32'h1, 1'b1, 0, "R3 second frame");              // E0+40
      wr(1, 32'h1);                                          // eff E0+42
      wr(0, 32'h1);                                          // restart eff E0+43
      rd(1, 32'h1, 1'b1, 0, "R2 re-enable sets bit");        // E0+43
      wr(1, 32'h1);                                          // eff E0+45
      rd(1, 32'h0, 1'b0, 0, "R5 ack after restart");         // E0+45
      idle(16);
      rd(1, 32'h0, 1'b0, 0, "R2 old schedule must not fire"); // E0+62
      rd(1, 32'h1, 1'b1, 0, "R2 restarted period fires");    // E0+63
      // R4 stop, R1 gating by enable
      wr(0, 32'h0);
      rd(1, 32'h1, 1'b0, 0, "R1 status held, irq gated off");
      rd(0, 32'h0, 1'b0, 0, "R4 enable cleared");
      wr(1, 32'h1);
      idle(30);
      rd(1, 32'h0, 1'b0, 0, "R4 no frame sets while stopped");
      // non-frame enable bit keeps timer stopped
      wr(0, 32'h0000_0100);
      rd(0, 32'h0000_0100, 1'b0, 0, "R6 enable other bit");
      idle(25);
      rd(1, 32'h0, 1'b0, 0, "R4 other enable bit leaves timer off");
      // R7 unmapped writes
      wr(2, 32'hFFFF_FFFF);
      wr(3, 32'hFFFF_FFFF);
      rd(0, 32'h0000_0100, 1'b0, 0, "R7 enable untouched");
      rd(1, 32'h0, 1'b0, 0, "R7 status untouched");
      rd(3, 32'h0, 1'b0, 0, "R6 unmapped reads zero");
      // R5 mask on variant 1, frame bit 4 outside its mask
      wr(0, 32'h0000_0010);
      rd(1, 32'h0000_0010, 1'b1, 1, "R2 variant 1 frame bit 4");
      wr(1, 32'h0000_0010);
      rd(1, 32'h0000_0010, 1'b1, 1, "R5 masked ack ignored");
      wr(1, 32'hFFFF_FFFF);
      rd(1, 32'h0000_0010, 1'b1, 1, "R5 masked all-ones ack ignored");
      rd(1, 32'h0, 1'b0, 0, "R4 variant 0 stopped by bit 4 write");
      // R8 reset mid-run
      pulse_reset();
      rd(0, 32'h0, 1'b0, 1, "R8 enable cleared by reset");
      rd(1, 32'h0, 1'b0, 1, "R8 status cleared by reset");
      idle(30);
      rd(1, 32'h0, 1'b0, 1, "R8 timer stopped by reset");
      rd(1, 32'h0, 1'b0, 0, "R8 variant 0 quiet after reset");
      idle(2);
      if (q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL R6: %0d reads not observed, expected 0", q.size());
      end
      finish_run();
   end
endmodule